// File: doc/BRIEF.md
# Predicated Vector Floating-Point Compare Against Zero

The block takes one wide vector, splits it into half, single or double precision lanes, and tests every lane against floating-point zero with one of six relations: equal, not equal, greater, greater-or-equal, less, less-or-equal. Each answer lands in a predicate that has one bit per byte of the vector. A lane owns as many predicate bits as it has bytes. Only the lowest of those bits carries the answer, and the others are always zero.

A governing predicate, laid out the same way, selects the lanes that take part. A lane whose governing bit is clear gets all-zero result bits. Less-than and less-or-equal are formed by a greater-type comparison with the operands swapped, so zero is on the left. NaN lanes are unordered. A flush input can treat subnormal lanes as signed zeros. A request is accepted on a one-cycle strobe. One cycle later the block shows the result and a done pulse. A reserved size code or an unused relation code raises an illegal flag, and the predicate is not written.

Top module: `vec_fzero_cmp`

## Requirements
- R1: sizeSel 2'b01, 2'b10 and 2'b11 select 16-, 32- and 64-bit lanes. Lane e writes its result to outPred bit e*(lane bits/8), and every other bit of its group is 0.
- R2: A lane is active only when govPred bit e*(lane bits/8) is 1. Inactive lanes give all-zero result bits.
- R3: cmpSel codes are GE=3'b000, GT=3'b001, LT=3'b010, LE=3'b011, EQ=3'b100 and NE=3'b110. LT means 0 > x and LE means 0 >= x.
- R4: sizeSel 2'b00, or cmpSel 3'b101 or 3'b111, raises illegal together with the done pulse, and outPred keeps its previous value.
- R5: A NaN lane gives 0 for EQ, GT, GE, LT and LE, and 1 for NE.
- R6: +0 and -0 are equal to zero. GE, LE and EQ give 1 for them, and GT, LT and NE give 0.
- R7: With flushSub=1, a subnormal lane counts as zero of its own sign. With flushSub=0, it counts as a nonzero value of its sign.
- R8: Every inValid strobe produces exactly one outValid pulse in the next cycle, with the new outPred. Without a strobe, outValid stays 0 and outPred holds its value. Back-to-back strobes are accepted on every cycle.
- R9: A synchronous active-high rst clears outPred, outValid and illegal to 0.
- R10: +infinity is greater than zero and -infinity is less than zero.
- R11: When no lane is active at the selected size, outPred is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request strobe |
| vecIn | input | VEC_W | Vector operand |
| govPred | input | VEC_W/8 | Governing predicate, one bit per byte |
| sizeSel | input | 2 | Lane size code |
| cmpSel | input | 3 | Relation code |
| flushSub | input | 1 | Treat subnormals as signed zero |
| outPred | output | VEC_W/8 | Result predicate |
| outValid | output | 1 | Done pulse, one cycle after inValid |
| illegal | output | 1 | Illegal encoding, valid with outValid |

## Verification
The bench builds the block with VEC_W=128. At that width a vector holds eight half, four single or two double lanes, so one short hand-written vector can place a NaN, both zeros, both infinities, both subnormal signs and normal values in lanes next to each other. At the same size, the governing-predicate patterns can set only the non-lowest bits of each group, reach the empty-predicate case, and reach single-lane cases. Seeded random requests then cover every legal size and relation code against an independent model.

// File: rtl/vfzc_pkg.sv
package vfzc_pkg;

  localparam logic [2:0] OP_GE = 3'b000;
  localparam logic [2:0] OP_GT = 3'b001;
  localparam logic [2:0] OP_LT = 3'b010;
  localparam logic [2:0] OP_LE = 3'b011;
  localparam logic [2:0] OP_EQ = 3'b100;
  localparam logic [2:0] OP_NE = 3'b110;

  localparam int NUM_SIZES = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic       fire;     // request accepted this cycle
    logic       write;    // result may be written
    logic       illegal;  // encoding rejected
    logic       swapOps;  // zero on the left-hand side
    logic       orEqual;  // include equality
    logic       eqOnly;   // pure equality test
    logic       invert;   // negate equality result
    logic [2:0] laneSel;  // one-hot {64,32,16}
  } ctrlStrobe_t;

  // Operand class used by the comparator
  typedef struct packed {
    logic nan;
    logic zero;
    logic neg;
  } fpClass_t;

  // Ordered "a greater than b", exact whenever one side is zero
  function automatic logic greaterThan(fpClass_t a, fpClass_t b);
    logic aPos;
    logic bNegNz;
    aPos   = !a.zero && !a.neg;
    bNegNz = !b.zero && b.neg;
    return !a.nan && !b.nan &&
           ((aPos && (b.zero || b.neg)) || (a.zero && bNegNz));
  endfunction

endpackage

// File: rtl/vfzc_ctrl.sv
module vfzc_ctrl
  import vfzc_pkg::*;
(
  input  logic        inValid,
  input  logic [1:0]  sizeSel,
  input  logic [2:0]  cmpSel,
  output ctrlStrobe_t strobe
);

  logic sizeBad;
  logic opBad;

  always_comb begin
    sizeBad = (sizeSel == 2'b00);
    opBad   = (cmpSel == 3'b101) || (cmpSel == 3'b111);

    strobe         = '0;
    strobe.fire    = inValid;
    strobe.illegal = sizeBad || opBad;
    strobe.write   = inValid && !(sizeBad || opBad);

    unique case (sizeSel)
      2'b01:   strobe.laneSel = 3'b001;
      2'b10:   strobe.laneSel = 3'b010;
      2'b11:   strobe.laneSel = 3'b100;
      default: strobe.laneSel = 3'b000;
    endcase

    case (cmpSel)
      OP_EQ: strobe.eqOnly = 1'b1;
      OP_NE: begin
        strobe.eqOnly = 1'b1;
        strobe.invert = 1'b1;
      end
      OP_GE: strobe.orEqual = 1'b1;
      OP_LT: strobe.swapOps = 1'b1;
      OP_LE: begin
        strobe.swapOps = 1'b1;
        strobe.orEqual = 1'b1;
      end
      default: ; // GT and illegal codes use the plain greater path
    endcase
  end

endmodule

// File: rtl/vfzc_dpath.sv
module vfzc_dpath
  import vfzc_pkg::*;
#(
  parameter int VEC_W = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobe_t        strobe,
  input  logic [VEC_W-1:0]   vecIn,
  input  logic [VEC_W/8-1:0] govPred,
  input  logic               flushSub,
  output logic [VEC_W/8-1:0] outPred,
  output logic               outValid,
  output logic               illegal
);

  localparam int PRED_W = VEC_W / 8;
  localparam logic [PRED_W-1:0] HALF_HI = {(PRED_W/2){2'b10}};

  logic [PRED_W-1:0] sizeRes [NUM_SIZES];
  logic [PRED_W-1:0] nextPred;

  localparam fpClass_t ZERO_CLS = '{nan: 1'b0, zero: 1'b1, neg: 1'b0};

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int ESZ   = 16 << s;
    localparam int EXPW  = (s == 0) ? 5 : ((s == 1) ? 8 : 11);
    localparam int MANW  = ESZ - 1 - EXPW;
    localparam int LANES = VEC_W / ESZ;
    localparam int PSTEP = ESZ / 8;

    logic [LANES-1:0]  laneAct;
    logic              anyAct;
    logic [PRED_W-1:0] laneBits;

    for (genvar l = 0; l < LANES; l++) begin : g_act
      assign laneAct[l] = govPred[l*PSTEP];
    end
    assign anyAct = |laneAct;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [ESZ-1:0]  elem;
      logic [EXPW-1:0] expo;
      logic [MANW-1:0] mant;
      fpClass_t        xCls;
      fpClass_t        lhs;
      fpClass_t        rhs;
      logic            isEq;
      logic            res;

      assign elem = anyAct ? vecIn[l*ESZ +: ESZ] : '0;
      assign expo = elem[ESZ-2 -: EXPW];
      assign mant = elem[MANW-1:0];

      assign xCls.nan  = (&expo) && (|mant);
      assign xCls.zero = (~|expo) && ((~|mant) || flushSub);
      assign xCls.neg  = elem[ESZ-1];

      assign lhs  = strobe.swapOps ? ZERO_CLS : xCls;
      assign rhs  = strobe.swapOps ? xCls : ZERO_CLS;
      assign isEq = !xCls.nan && xCls.zero;
      assign res  = strobe.eqOnly ? (isEq ^ strobe.invert)
                                  : (greaterThan(lhs, rhs) || (strobe.orEqual && isEq));

      assign laneBits[l*PSTEP +: PSTEP] = {{(PSTEP-1){1'b0}}, laneAct[l] && res};
    end

    assign sizeRes[s] = laneBits;
  end

  always_comb begin
    nextPred = '0;
    for (int s = 0; s < NUM_SIZES; s++) begin
      if (strobe.laneSel[s]) nextPred = sizeRes[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outPred  <= '0;
      outValid <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      outValid <= strobe.fire;
      illegal  <= strobe.fire && strobe.illegal;
      if (strobe.write) outPred <= nextPred;
    end
  end

  // R8: one done pulse per accepted strobe, none otherwise
  a_r8_done_follows: assert property (@(posedge clk) disable iff (rst)
    strobe.fire |=> outValid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !strobe.fire |=> !outValid);
  // R4: rejected request leaves the predicate untouched
  a_r4_illegal_holds: assert property (@(posedge clk) disable iff (rst)
    illegal |-> $stable(outPred));
  a_r4_illegal_with_done: assert property (@(posedge clk) disable iff (rst)
    illegal |-> outValid);
  // R2: result bits only where the governing predicate was set
  a_r2_inactive_zero: assert property (@(posedge clk) disable iff (rst)
    (outValid && !illegal) |-> ((outPred & ~$past(govPred)) == '0));
  // R1: 16-bit lanes never set the upper bit of their pair
  a_r1_half_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (outValid && !illegal && $past(strobe.laneSel[0])) |-> ((outPred & HALF_HI) == '0));

endmodule

// File: rtl/vec_fzero_cmp.sv
module vec_fzero_cmp
  import vfzc_pkg::*;
#(
  parameter int VEC_W = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [VEC_W-1:0]   vecIn,
  input  logic [VEC_W/8-1:0] govPred,
  input  logic [1:0]         sizeSel,
  input  logic [2:0]         cmpSel,
  input  logic               flushSub,
  output logic [VEC_W/8-1:0] outPred,
  output logic               outValid,
  output logic               illegal
);

  ctrlStrobe_t strobe;

  vfzc_ctrl i_ctrl (
    .inValid (inValid),
    .sizeSel (sizeSel),
    .cmpSel  (cmpSel),
    .strobe  (strobe)
  );

  vfzc_dpath #(.VEC_W(VEC_W)) i_dpath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .vecIn    (vecIn),
    .govPred  (govPred),
    .flushSub (flushSub),
    .outPred  (outPred),
    .outValid (outValid),
    .illegal  (illegal)
  );

  // R4: reserved size code is always flagged
  a_r4_reserved_size: assert property (@(posedge clk) disable iff (rst)
    (inValid && sizeSel == 2'b00) |=> illegal);
  // R4: legal codes are never flagged
  a_r4_legal_clean: assert property (@(posedge clk) disable iff (rst)
    (inValid && sizeSel != 2'b00 && cmpSel != 3'b101 && cmpSel != 3'b111) |=> !illegal);

endmodule

// File: tb/test_vec_fzero_cmp.sv
module test_vec_fzero_cmp;

  localparam int VW = 128;
  localparam int PW = VW / 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inValid = 1'b0;
  logic [VW-1:0] vecIn = '0;
  logic [PW-1:0] govPred = '0;
  logic [1:0]    sizeSel = 2'b01;
  logic [2:0]    cmpSel = 3'b000;
  logic          flushSub = 1'b0;
  logic [PW-1:0] outPred;
  logic          outValid;
  logic          illegal;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic [PW-1:0] qPred [$];
  logic          qIll  [$];
  string         qTag  [$];
  logic [PW-1:0] lastPred = '0;

  always #5 clk = ~clk;

  vec_fzero_cmp #(.VEC_W(VW)) i_vec_fzero_cmp (
    .clk(clk), .rst(rst), .inValid(inValid), .vecIn(vecIn), .govPred(govPred),
    .sizeSel(sizeSel), .cmpSel(cmpSel), .flushSub(flushSub),
    .outPred(outPred), .outValid(outValid), .illegal(illegal)
  );

  function automatic logic [2:0] opOf(int k);
    case (k)
      0: return 3'b000; // GE
      1: return 3'b001; // GT
      2: return 3'b010; // LT
      3: return 3'b011; // LE
      4: return 3'b100; // EQ
      default: return 3'b110; // NE
    endcase
  endfunction

  // Independent reference written from R1-style rules
  function automatic logic [PW-1:0] model(logic [VW-1:0] v, logic [PW-1:0] g,
                                          logic [1:0] sz, logic [2:0] op, logic ftz);
    logic [PW-1:0] r;
    int eb, ew, pb, n;
    r  = '0;
    eb = 8 << sz;
    ew = (sz == 2'b01) ? 5 : ((sz == 2'b10) ? 8 : 11);
    pb = eb / 8;
    n  = VW / eb;
    for (int e = 0; e < n; e++) begin
      logic [63:0] x, ex, mn, em;
      logic sgn, nan, zer, pos, negv, bitv;
      if (g[e*pb]) begin
        x   = 64'(v >> (e*eb));
        if (eb < 64) x = x & ((64'd1 << eb) - 64'd1);
        sgn = x[eb-1];
        em  = (64'd1 << ew) - 64'd1;
        ex  = (x >> (eb-1-ew)) & em;
        mn  = x & ((64'd1 << (eb-1-ew)) - 64'd1);
        nan = (ex == em) && (mn != 0);
        zer = (ex == 0) && ((mn == 0) || ftz);
        pos = !nan && !zer && !sgn;
        negv = !nan && !zer && sgn;
        case (op)
          3'b100:  bitv = zer;
          3'b110:  bitv = !zer;
          3'b001:  bitv = pos;
          3'b000:  bitv = pos || zer;
          3'b010:  bitv = negv;
          default: bitv = negv || zer;
        endcase
        r[e*pb] = bitv;
      end
    end
    return r;
  endfunction

  // Driver: caller is positioned at a negedge
  task automatic drive(logic [VW-1:0] v, logic [PW-1:0] g, logic [1:0] sz,
                       logic [2:0] op, logic ftz, string tag);
    logic ill;
    logic [PW-1:0] e;
    ill = (sz == 2'b00) || (op == 3'b101) || (op == 3'b111);
    e   = ill ? lastPred : model(v, g, sz, op, ftz);
    lastPred = e;
    qPred.push_back(e);
    qIll.push_back(ill);
    qTag.push_back(tag);
    vecIn = v; govPred = g; sizeSel = sz; cmpSel = op; flushSub = ftz;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic check(bit ok, string tag, logic [PW-1:0] act, logic [PW-1:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (qPred.size() == 0) begin
        check(1'b0, "R8 unexpected done", outPred, '0);
      end else begin
        logic [PW-1:0] ep;
        logic ei;
        string t;
        ep = qPred.pop_front();
        ei = qIll.pop_front();
        t  = qTag.pop_front();
        check(outPred == ep && illegal == ei, t, {outPred[PW-2:0], illegal}, {ep[PW-2:0], ei});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] hv, hv2, sv, dv, dv2;
    // lanes listed high to low
    hv  = {16'hFC00, 16'h7C00, 16'h7E00, 16'h8001, 16'h0001, 16'h8000, 16'h0000, 16'hBC00};
    hv2 = {16'h3C00, 16'h0001, 16'h8001, 16'h7C01, 16'hC000, 16'h4000, 16'h0000, 16'h8000};
    sv  = {32'hBF800000, 32'h7FC00000, 32'h80000001, 32'h3F800000};
    dv  = {64'h8000000000000000, 64'h3FF0000000000000};
    dv2 = {64'hFFF0000000000000, 64'h7FF8000000000001};

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check(outPred == '0 && !outValid && !illegal, "R9 reset state", outPred, '0);

    // R3 R5 R6 R10 R1: every relation on mixed half lanes
    for (int k = 0; k < 6; k++) begin
      drive(hv,  '1, 2'b01, opOf(k), 1'b0, "R3 R5 R6 R10 half lanes");
      drive(hv2, '1, 2'b01, opOf(k), 1'b0, "R1 R5 R6 half lanes");
      drive(hv,  '1, 2'b01, opOf(k), 1'b1, "R7 half flush on");
      drive(sv,  '1, 2'b10, opOf(k), 1'b0, "R1 R5 single lanes");
      drive(sv,  '1, 2'b10, opOf(k), 1'b1, "R7 single flush on");
      drive(dv,  '1, 2'b11, opOf(k), 1'b0, "R1 R6 double lanes");
      drive(dv2, '1, 2'b11, opOf(k), 1'b0, "R5 R10 double lanes");
    end

    // R2: partial governing predicate
    drive(hv, 16'h0505, 2'b01, 3'b110, 1'b0, "R2 half partial");
    drive(sv, 16'h0F01, 2'b10, 3'b000, 1'b0, "R2 single partial");
    drive(dv, 16'h00FF, 2'b11, 3'b000, 1'b0, "R2 double partial");
    // R11: only non-lowest bits set
    drive(hv, 16'hAAAA, 2'b01, 3'b110, 1'b0, "R11 half none active");
    drive(dv, 16'hFEFE, 2'b11, 3'b100, 1'b0, "R11 double none active");
    drive(sv, 16'h0000, 2'b10, 3'b110, 1'b0, "R11 empty predicate");

    // R4: illegal codes keep previous predicate
    drive(hv, '1, 2'b01, 3'b110, 1'b0, "R4 setup");
    drive(hv2, '1, 2'b00, 3'b100, 1'b0, "R4 reserved size");
    drive(hv2, '1, 2'b01, 3'b101, 1'b0, "R4 code 101");
    drive(hv2, '1, 2'b10, 3'b111, 1'b0, "R4 code 111");

    // R8: idle cycles, predicate held, no done
    repeat (4) begin
      @(negedge clk);
      check(!outValid && outPred == lastPred, "R8 idle hold", outPred, lastPred);
    end

    // Random legal traffic
    for (int i = 0; i < 60; i++) begin
      logic [VW-1:0] rv;
      logic [PW-1:0] rg;
      logic [1:0] rs;
      rv = {$urandom, $urandom, $urandom, $urandom};
      rg = PW'($urandom);
      rs = 2'($urandom_range(1, 3));
      drive(rv, rg, rs, opOf($urandom_range(0, 5)), 1'($urandom), "R1 R2 R3 random");
    end

    repeat (3) @(negedge clk);
    check(qPred.size() == 0, "R8 all results seen", PW'(qPred.size()), '0);

    // R9: reset mid-run clears state
    drive(hv, '1, 2'b01, 3'b110, 1'b0, "R9 before reset");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    lastPred = '0;
    check(outPred == '0 && !outValid && !illegal, "R9 reset clears", outPred, '0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule